// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block draws into a linear frame buffer of 16-bit pixels on behalf of a processor. Software programs a small bank of registers through a simple write/read port. One group of registers describes a solid-colour rectangle. A second group describes a rectangular copy from a source origin to a destination origin. Writing the final register of a group launches that operation.

While the engine works, it holds `cpu_ready` low so the processor stalls until the rectangle is done. On the memory side it issues single-word requests. Each request is held until the RAM grants it. Read data returns later with a valid strobe.

Each pixel of the surface lives at word address `y*SCREEN_W + x`. The pixel word is a 5-6-5 colour: red in bits 15:11, green in 10:5 and blue in 4:0. The engine carries it through unchanged. The surface defaults to 1920 by 1080 pixels.

Top module: `rect_blit_engine`

## Requirements
- R1: After reset, `cpu_ready` is 1, `mem_req` is 0 and every register reads back as 0.
- R2: Register indices on `cpu_addr` are 0 fill colour, 1 fill width-length, 2 fill height-length, 3 fill X, 4 fill Y, 5 copy width-length, 6 copy height-length, 7 source X, 8 source Y, 9 destination X, 10 destination Y. Each register reads back on `cpu_rdata` the last value written to it. Indices 11 to 15 read as 0.
- R3: A fill writes the fill colour word, unchanged, to every pixel at address y*SCREEN_W+x inside the rectangle. No other address is written.
- R4: A write to index 4 while `cpu_ready` is 1 starts a fill using the register values including that write. `cpu_ready` is 0 from the next cycle and returns to 1 in the cycle after the last pixel write is granted. `mem_req` is only raised while `cpu_ready` is 0.
- R5: A copy reads each source pixel and writes the returned word to the matching destination pixel. After a read is granted, no new request is made until its data returns.
- R6: A write to index 10 while `cpu_ready` is 1 starts a copy, with `cpu_ready` 0 from the next cycle.
- R7: Fills, and copies whose destination origin is not after the source origin in raster order, visit pixels row by row, left to right and top to bottom.
- R8: A copy whose destination origin is after the source origin in raster order (lower row, or same row and further right) visits pixels in reverse: bottom row first, right to left. Overlapping copies therefore give the same result as copying from an untouched source.
- R9: A write to index 4 or 10 while an operation runs starts nothing, but the written value is still stored.
- R10: A memory request keeps its address, direction and data unchanged until `mem_gnt` is seen.
- R11: A length value N covers N+1 pixels. Lengths 0 and 0 touch one pixel. Lengths SCREEN_W-1 and SCREEN_H-1 at origin 0,0 cover the whole surface.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 4 | Register index |
| cpu_wdata | input | WORD_W | Register write data |
| cpu_rdata | output | WORD_W | Read data of the indexed register |
| cpu_ready | output | 1 | 1 when idle; 0 holds the processor |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Pixel word address |
| mem_wdata | output | WORD_W | Pixel write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | WORD_W | Read data |

## Verification
Some properties are checked on every cycle. A pending memory request stays stable until granted. No request appears while the processor is free. Ready falls right after a start write, and only then. A granted read is followed by a quiet request line. The correctness of pixel addresses and colours, and the visiting order, are shown only by the bench's scenarios. So are the overlap results of reverse copies, and the fact that a start during a busy operation is ignored. The bench drives these under both steady and irregular grant patterns.

// File: rtl/rbe_pkg.sv
package rbe_pkg;
  localparam int NUM_REGS       = 11;
  localparam int RI_FILL_COLOUR = 0;
  localparam int RI_FILL_W      = 1;
  localparam int RI_FILL_H      = 2;
  localparam int RI_FILL_X      = 3;
  localparam int RI_FILL_Y      = 4;
  localparam int RI_COPY_W      = 5;
  localparam int RI_COPY_H      = 6;
  localparam int RI_SRC_X       = 7;
  localparam int RI_SRC_Y       = 8;
  localparam int RI_DST_X       = 9;
  localparam int RI_DST_Y       = 10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_RD,
    ST_RD_WAIT,
    ST_WR
  } eng_state_e;
endpackage

// File: rtl/rbe_regfile.sv
module rbe_regfile import rbe_pkg::*; #(
  parameter int WORD_W = 16,
  parameter int RA_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [RA_W-1:0]   cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic [WORD_W-1:0] regs_nx [NUM_REGS]
);
  logic [WORD_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = cpu_wr && (cpu_addr == RA_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (hit) begin
        regs_q[g] <= cpu_wdata;
      end
    end

    // value the register holds after this cycle's write
    assign regs_nx[g] = hit ? cpu_wdata : regs_q[g];
  end

  always_comb begin
    cpu_rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (cpu_addr == RA_W'(i)) begin
        cpu_rdata = regs_q[i];
      end
    end
  end
endmodule

// File: rtl/rbe_walker.sv
module rbe_walker #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              rev_in,
  input  logic [WORD_W-1:0] w_in,
  input  logic [WORD_W-1:0] h_in,
  input  logic              step,
  output logic [WORD_W-1:0] cx,
  output logic [WORD_W-1:0] cy,
  output logic              last
);
  logic              rev_q, rev_d;
  logic [WORD_W-1:0] w_q, w_d, h_q, h_d, cx_q, cx_d, cy_q, cy_d;

  always_comb begin
    rev_d = rev_q;
    w_d   = w_q;
    h_d   = h_q;
    cx_d  = cx_q;
    cy_d  = cy_q;
    if (load) begin
      rev_d = rev_in;
      w_d   = w_in;
      h_d   = h_in;
      cx_d  = rev_in ? w_in : '0;
      cy_d  = rev_in ? h_in : '0;
    end else if (step) begin
      if (!rev_q) begin
        if (cx_q == w_q) begin
          cx_d = '0;
          cy_d = cy_q + 1'b1;
        end else begin
          cx_d = cx_q + 1'b1;
        end
      end else begin
        if (cx_q == '0) begin
          cx_d = w_q;
          cy_d = cy_q - 1'b1;
        end else begin
          cx_d = cx_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rev_q <= 1'b0;
      w_q   <= '0;
      h_q   <= '0;
      cx_q  <= '0;
      cy_q  <= '0;
    end else if (load || step) begin
      rev_q <= rev_d;
      w_q   <= w_d;
      h_q   <= h_d;
      cx_q  <= cx_d;
      cy_q  <= cy_d;
    end
  end

  assign cx   = cx_q;
  assign cy   = cy_q;
  assign last = rev_q ? ((cx_q == '0) && (cy_q == '0))
                      : ((cx_q == w_q) && (cy_q == h_q));
endmodule

// File: rtl/rbe_addr.sv
module rbe_addr #(
  parameter int SCREEN_W = 1920,
  parameter int WORD_W   = 16,
  parameter int ADDR_W   = 21
) (
  input  logic [WORD_W-1:0] org_x,
  input  logic [WORD_W-1:0] org_y,
  input  logic [WORD_W-1:0] off_x,
  input  logic [WORD_W-1:0] off_y,
  output logic [ADDR_W-1:0] addr
);
  localparam int LW = 2 * WORD_W;
  localparam logic [LW-1:0] STRIDE = LW'(SCREEN_W);

  logic [WORD_W-1:0] px, py;

  always_comb begin
    px   = WORD_W'(org_x + off_x);
    py   = WORD_W'(org_y + off_y);
    addr = ADDR_W'(({{WORD_W{1'b0}}, py} * STRIDE) + {{WORD_W{1'b0}}, px});
  end
endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine import rbe_pkg::*; #(
  parameter int SCREEN_W = 1920,
  parameter int SCREEN_H = 1080,
  parameter int WORD_W   = 16,
  localparam int ADDR_W  = $clog2(SCREEN_W * SCREEN_H),
  localparam int RA_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [RA_W-1:0]   cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i_n = rst_sync_q[1];

  logic [WORD_W-1:0] regs_nx [NUM_REGS];

  rbe_regfile #(.WORD_W(WORD_W), .RA_W(RA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .regs_nx   (regs_nx)
  );

  logic fill_go, copy_go, dst_later;
  assign fill_go = cpu_wr && (cpu_addr == RA_W'(RI_FILL_Y));
  assign copy_go = cpu_wr && (cpu_addr == RA_W'(RI_DST_Y));
  assign dst_later = (regs_nx[RI_DST_Y] > regs_nx[RI_SRC_Y]) ||
                     ((regs_nx[RI_DST_Y] == regs_nx[RI_SRC_Y]) &&
                      (regs_nx[RI_DST_X] > regs_nx[RI_SRC_X]));

  eng_state_e state_q, state_d;
  logic load, step, snap_en, cap_en;
  logic [WORD_W-1:0] len_w, len_h, org_x_nx, org_y_nx;
  logic rev_nx;
  logic [WORD_W-1:0] cx, cy;
  logic last;

  // operation parameters captured at launch
  logic [WORD_W-1:0] org_x_q, org_y_q, src_x_q, src_y_q, colour_q, data_q;

  always_comb begin
    len_w    = fill_go ? regs_nx[RI_FILL_W] : regs_nx[RI_COPY_W];
    len_h    = fill_go ? regs_nx[RI_FILL_H] : regs_nx[RI_COPY_H];
    org_x_nx = fill_go ? regs_nx[RI_FILL_X] : regs_nx[RI_DST_X];
    org_y_nx = fill_go ? regs_nx[RI_FILL_Y] : regs_nx[RI_DST_Y];
    rev_nx   = !fill_go && dst_later;
  end

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    step    = 1'b0;
    snap_en = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fill_go) begin
          state_d = ST_FILL;
          load    = 1'b1;
          snap_en = 1'b1;
        end else if (copy_go) begin
          state_d = ST_RD;
          load    = 1'b1;
          snap_en = 1'b1;
        end
      end
      ST_FILL: begin
        if (mem_gnt) begin
          if (last) state_d = ST_IDLE;
          else      step    = 1'b1;
        end
      end
      ST_RD: begin
        if (mem_gnt) state_d = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (mem_rvalid) begin
          cap_en  = 1'b1;
          state_d = ST_WR;
        end
      end
      ST_WR: begin
        if (mem_gnt) begin
          if (last) begin
            state_d = ST_IDLE;
          end else begin
            step    = 1'b1;
            state_d = ST_RD;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk) begin
    if (snap_en) begin
      org_x_q  <= org_x_nx;
      org_y_q  <= org_y_nx;
      src_x_q  <= regs_nx[RI_SRC_X];
      src_y_q  <= regs_nx[RI_SRC_Y];
      colour_q <= regs_nx[RI_FILL_COLOUR];
    end
    if (cap_en) begin
      data_q <= mem_rdata;
    end
  end

  rbe_walker #(.WORD_W(WORD_W)) u_walk (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .load   (load),
    .rev_in (rev_nx),
    .w_in   (len_w),
    .h_in   (len_h),
    .step   (step),
    .cx     (cx),
    .cy     (cy),
    .last   (last)
  );

  logic [ADDR_W-1:0] dst_addr, src_addr;

  rbe_addr #(.SCREEN_W(SCREEN_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dst_addr (
    .org_x (org_x_q),
    .org_y (org_y_q),
    .off_x (cx),
    .off_y (cy),
    .addr  (dst_addr)
  );

  rbe_addr #(.SCREEN_W(SCREEN_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_src_addr (
    .org_x (src_x_q),
    .org_y (src_y_q),
    .off_x (cx),
    .off_y (cy),
    .addr  (src_addr)
  );

  always_comb begin
    cpu_ready = (state_q == ST_IDLE);
    mem_req   = (state_q == ST_FILL) || (state_q == ST_RD) || (state_q == ST_WR);
    mem_we    = (state_q == ST_FILL) || (state_q == ST_WR);
    mem_addr  = (state_q == ST_RD) ? src_addr : dst_addr;
    mem_wdata = (state_q == ST_FILL) ? colour_q : data_q;
  end
endmodule

// File: rtl/rbe_checker.sv
module rbe_checker import rbe_pkg::*; #(
  parameter int RA_W   = 4,
  parameter int ADDR_W = 21,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_wr,
  input logic [RA_W-1:0]   cpu_addr,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              mem_gnt
);
  logic fill_start, copy_start;
  assign fill_start = cpu_wr && (cpu_addr == RA_W'(RI_FILL_Y));
  assign copy_start = cpu_wr && (cpu_addr == RA_W'(RI_DST_Y));

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10

  AST_FILL_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && fill_start |=> !cpu_ready); // R4

  AST_COPY_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && copy_start |=> !cpu_ready); // R6

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && !fill_start && !copy_start |=> cpu_ready); // R9

  AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_gnt |=> !mem_req); // R5
endmodule

bind rect_blit_engine rbe_checker #(.RA_W(RA_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_wr    (cpu_wr),
  .cpu_addr  (cpu_addr),
  .cpu_ready (cpu_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_gnt   (mem_gnt)
);

// File: tb/tb_rect_blit_engine.sv
module tb_rect_blit_engine;
  localparam int CLK_P = 10;
  localparam int SW    = 16;
  localparam int SH    = 8;
  localparam int NPIX  = SW * SH;
  localparam int AW    = $clog2(NPIX);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_wr;
  logic [3:0]  cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic        cpu_ready;
  logic        mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        gnt_q, rvalid_q;
  logic [15:0] rdata_q;

  always #(CLK_P/2) clk = ~clk;

  rect_blit_engine #(.SCREEN_W(SW), .SCREEN_H(SH), .WORD_W(16)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(gnt_q), .mem_rvalid(rvalid_q), .mem_rdata(rdata_q)
  );

  // memory model
  logic [15:0] vram [NPIX];
  logic [15:0] lfsr;
  int          gnt_mode = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      lfsr     <= 16'hACE1;
      gnt_q    <= 1'b0;
      rvalid_q <= 1'b0;
      for (int i = 0; i < NPIX; i++) vram[i] <= 16'h1000 + 16'(i);
    end else begin
      lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      gnt_q    <= (gnt_mode == 0) ? 1'b1 : (lfsr[0] ^ lfsr[5]);
      rvalid_q <= mem_req && !mem_we && gnt_q;
      if (mem_req && gnt_q) begin
        if (mem_we) vram[mem_addr] <= mem_wdata;
        else        rdata_q <= vram[mem_addr];
      end
    end
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard
  int          q_addr [$];
  logic [15:0] q_data [$];
  string       q_tag  [$];
  bit          ready_due = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ready_due) begin
        check(cpu_ready == 1'b1, "R4", "ready after last write", int'(cpu_ready), 1);
        ready_due = 1'b0;
      end
      if (mem_req && mem_we && gnt_q) begin
        if (q_addr.size() == 0) begin
          check(1'b0, "R9", "unexpected write addr", int'(mem_addr), -1);
        end else begin
          automatic int          ea = q_addr.pop_front();
          automatic logic [15:0] ed = q_data.pop_front();
          automatic string       et = q_tag.pop_front();
          check(int'(mem_addr) == ea, et, "write address", int'(mem_addr), ea);
          check(mem_wdata == ed, et, "write data", int'(mem_wdata), int'(ed));
          check(cpu_ready == 1'b0, "R4", "ready low while writing", int'(cpu_ready), 0);
          if (q_addr.size() == 0) ready_due = 1'b1;
        end
      end
    end
  end

  logic [15:0] exp_mem [NPIX];
  logic [15:0] shadow [11];

  task automatic cpu_write(input int a, input logic [15:0] d);
    @(negedge clk);
    cpu_wr    = 1'b1;
    cpu_addr  = 4'(a);
    cpu_wdata = d;
    @(negedge clk);
    cpu_wr    = 1'b0;
    if (a < 11) shadow[a] = d;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (!cpu_ready && n < 5000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    check(q_addr.size() == 0, req, "pending writes after op", q_addr.size(), 0);
  endtask

  task automatic compare_mem(input string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < NPIX; i++) begin
      if (vram[i] !== exp_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) check(1'b1, req, "frame contents", 0, 0);
    else check(1'b0, req, "frame word mismatch", int'(vram[first]), int'(exp_mem[first]));
  endtask

  task automatic do_fill(input logic [15:0] c, input int x, input int y,
                         input int w, input int h, input string req);
    for (int yy = 0; yy <= h; yy++) begin
      for (int xx = 0; xx <= w; xx++) begin
        q_addr.push_back((y + yy) * SW + x + xx);
        q_data.push_back(c);
        q_tag.push_back(req);
        exp_mem[(y + yy) * SW + x + xx] = c;
      end
    end
    cpu_write(0, c);
    cpu_write(1, 16'(w));
    cpu_write(2, 16'(h));
    cpu_write(3, 16'(x));
    cpu_write(4, 16'(y));
    check(cpu_ready == 1'b0, "R4", "ready low after fill start", int'(cpu_ready), 0);
    wait_idle(req);
    compare_mem(req);
  endtask

  task automatic do_copy(input int sx, input int sy, input int dx, input int dy,
                         input int w, input int h, input string req);
    logic [15:0] snap [NPIX];
    bit rev;
    for (int i = 0; i < NPIX; i++) snap[i] = exp_mem[i];
    rev = (dy > sy) || ((dy == sy) && (dx > sx));
    for (int k = 0; k < (w + 1) * (h + 1); k++) begin
      automatic int lin = rev ? ((w + 1) * (h + 1) - 1 - k) : k;
      automatic int ox  = lin % (w + 1);
      automatic int oy  = lin / (w + 1);
      automatic int da  = (dy + oy) * SW + dx + ox;
      automatic int sa  = (sy + oy) * SW + sx + ox;
      q_addr.push_back(da);
      q_data.push_back(snap[sa]);
      q_tag.push_back(req);
      exp_mem[da] = snap[sa];
    end
    cpu_write(5, 16'(w));
    cpu_write(6, 16'(h));
    cpu_write(7, 16'(sx));
    cpu_write(8, 16'(sy));
    cpu_write(9, 16'(dx));
    cpu_write(10, 16'(dy));
    check(cpu_ready == 1'b0, "R6", "ready low after copy start", int'(cpu_ready), 0);
    wait_idle(req);
    compare_mem(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R4", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    for (int i = 0; i < 11; i++) shadow[i] = '0;
    for (int i = 0; i < NPIX; i++) exp_mem[i] = 16'h1000 + 16'(i);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(cpu_ready == 1'b1, "R1", "ready after reset", int'(cpu_ready), 1);
    check(mem_req == 1'b0, "R1", "no request after reset", int'(mem_req), 0);
    for (int a = 0; a < 11; a++) begin
      cpu_addr = 4'(a);
      #1;
      check(cpu_rdata == 16'h0, "R1", "register zero after reset", int'(cpu_rdata), 0);
    end

    // R5 R7 non-overlapping forward copy
    do_copy(8, 4, 1, 0, 3, 1, "R5");
    // R8 overlapping copy down-right, reverse order
    do_copy(2, 2, 3, 3, 4, 2, "R8");
    // R8 same-row shift right
    gnt_mode = 1;
    do_copy(0, 6, 2, 6, 5, 0, "R8");
    // R7 overlapping copy up-left, forward order
    do_copy(5, 4, 4, 3, 3, 2, "R7");
    gnt_mode = 0;

    // R3 R7 small fill with a 5-6-5 colour
    do_fill(16'hF81F, 2, 1, 2, 1, "R3");
    // R11 single pixel
    do_fill(16'h07E0, 13, 6, 0, 0, "R11");

    // R9 start while busy is ignored, value stored
    gnt_mode = 1;
    for (int yy = 0; yy <= 3; yy++)
      for (int xx = 0; xx < SW; xx++) begin
        q_addr.push_back(yy * SW + xx);
        q_data.push_back(16'h001F);
        q_tag.push_back("R9");
        exp_mem[yy * SW + xx] = 16'h001F;
      end
    cpu_write(0, 16'h001F);
    cpu_write(1, 16'(SW - 1));
    cpu_write(2, 16'd3);
    cpu_write(3, 16'd0);
    cpu_write(4, 16'd0);
    cpu_write(4, 16'd5);
    cpu_write(10, 16'd2);
    check(cpu_ready == 1'b0, "R9", "still busy after ignored starts", int'(cpu_ready), 0);
    wait_idle("R9");
    repeat (12) @(negedge clk);
    check(cpu_ready == 1'b1, "R9", "no extra operation", int'(cpu_ready), 1);
    compare_mem("R9");
    cpu_addr = 4'd4;
    #1;
    check(cpu_rdata == 16'd5, "R9", "busy write stored", int'(cpu_rdata), 5);

    // R11 R10 whole-surface clear under irregular grants
    do_fill(16'h0000, 0, 0, SW - 1, SH - 1, "R11");
    gnt_mode = 0;

    // R2 readback of every register plus unmapped indices
    for (int a = 0; a < 16; a++) begin
      automatic logic [15:0] e = (a < 11) ? shadow[a] : 16'h0;
      @(negedge clk);
      cpu_addr = 4'(a);
      #1;
      check(cpu_rdata == e, "R2", "register readback", int'(cpu_rdata), int'(e));
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule